// File: doc/BRIEF.md
# Single-Rank SDR SDRAM Controller with Host-Driven Command Modes

This controller sits between a simple host request port and one 16-bit SDR SDRAM with two banks, 11 row bits and 8 column bits. Each host access opens one row, moves one 16-bit word, and closes the row again. The controller spaces the activate, precharge and refresh commands according to a timing register, and it issues periodic auto-refresh from a programmable interval counter.

The device is not brought up by a built-in sequencer. Software first picks a command in a small mode register. Each host request then puts exactly that one command on the pins, with no data transfer. Power-up is therefore a run of register writes and dummy accesses: NOP, precharge-all, eight auto-refreshes, load-mode, then normal mode. The 200 µs quiet time before the first command is also the host's job. Mode value 0 turns host requests into real reads and writes, and the first write of 0 to the mode register starts the refresh counter.

Top module: `sdr_ctrl`

## Requirements
- R1: While reset is held, CKE is low, the pins carry NOP and done is low. From the first clock edge after reset release, CKE is high and stays high.
- R2: The command pins {cs_n,ras_n,cas_n,we_n} use these encodings: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO-REFRESH 0001 and LOAD MODE 0000. Data is driven on DQ only in a WRITE cycle.
- R3: The mode register (select 1, bits [2:0]) defaults to 1. Values: 0 normal, 1 NOP, 2 precharge-all, 3 load mode, 4 auto-refresh, 5 extended load mode. While the mode is nonzero, each host request issues that one command, pulses done, and issues no ACTIVE, READ or WRITE.
- R4: Precharge-all drives A10 high. Load mode drives BA=0 and A=0x030, which sets CAS latency 3 and burst length 1. Extended load mode drives BA=1 and A=0.
- R5: A normal write issues ACTIVE, then WRITE exactly tRCD cycles later. The WRITE cycle carries the write data on DQ and DQM equal to the inverted byte strobes.
- R6: A normal read issues ACTIVE, then READ exactly tRCD cycles later. The read data returned with done is the DQ value seen 3 cycles after the READ cycle.
- R7: Every access ends with a single-bank PRECHARGE with A10 low. This PRECHARGE comes at least tRAS cycles after its ACTIVE and, for writes, at least tWR cycles after the WRITE. Done pulses in the PRECHARGE cycle.
- R8: An ACTIVE or AUTO-REFRESH comes at least tRC cycles after the previous ACTIVE or AUTO-REFRESH, and at least tRP cycles after the last PRECHARGE.
- R9: The refresh interval (select 2) is counted in cycles and only once mode 0 has been written. Writing the interval restarts the count, a value of 0 stops refresh, and when idle the refreshes come exactly one interval apart.
- R10: A refresh that falls due during an access is served once that access ends and before the next request. No refresh is lost while accesses run back to back.
- R11: The host address splits, from bit 0 upward, into a byte bit (ignored), 8 column bits, 11 row bits and 1 bank bit. ACTIVE carries the row on A. READ and WRITE carry the column on A[7:0] with the upper bits low.
- R12: The timing register (select 0) holds 4-bit cycle counts: tWR in [3:0], tRCD in [7:4], tRP in [11:8], tRAS in [15:12] and tRC in [19:16]. The reset values are 4, 5, 5, 8 and 11. A new value governs every access that starts after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, also the SDRAM clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 timing, 1 mode, 2 refresh interval |
| reg_wdata | input | 32 | Register write data |
| host_req | input | 1 | Access request, held until done |
| host_wr | input | 1 | 1 write, 0 read |
| host_addr | input | 21 | Byte address: byte bit, column, row, bank |
| host_wdata | input | 16 | Write data |
| host_be | input | 2 | Byte strobes, active high |
| host_rdata | output | 16 | Read data, valid with done |
| host_done | output | 1 | One-cycle completion pulse |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 1 | Bank address |
| sd_a | output | 11 | Multiplexed row/column/mode address |
| sd_dq_out | output | 16 | Data driven to the device |
| sd_dq_oe | output | 1 | Output enable for the data bus |
| sd_dq_in | input | 16 | Data returned from the device |
| sd_dqm | output | 2 | Byte masks, high masks a lane |

## Verification
The hardest case to reach from the ports is a refresh falling due while an access is in progress, so that the refresh has to wait and then obey the spacing left behind by that access's precharge and activate. The stimulus sets a short refresh interval of 45 cycles and runs long strings of back-to-back random reads and writes, first with the default timings and then with tighter ones. The expiry then lands in every phase of an access. A pin monitor checks each ACTIVE, REFRESH and PRECHARGE spacing, and the refresh total is compared with the elapsed time. Quiet windows with a larger interval check the exact period. A separate window with an interval of zero checks that refresh stays off.

// File: rtl/sdr_ctrl.sv
module sdr_ctrl #(
  parameter int ROW_W    = 11,
  parameter int COL_W    = 8,
  parameter int BANK_W   = 1,
  parameter int DQ_W     = 16,
  parameter int CAS_LAT  = 3,
  parameter int TF_W     = 4,
  parameter int RT_W     = 16,
  parameter int WAIT_W   = 8,
  parameter int DEF_TWR  = 4,
  parameter int DEF_TRCD = 5,
  parameter int DEF_TRP  = 5,
  parameter int DEF_TRAS = 8,
  parameter int DEF_TRC  = 11
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_wr,
  input  logic [1:0]                    reg_sel,
  input  logic [31:0]                   reg_wdata,
  input  logic                          host_req,
  input  logic                          host_wr,
  input  logic [BANK_W+ROW_W+COL_W:0]   host_addr,
  input  logic [DQ_W-1:0]               host_wdata,
  input  logic [DQ_W/8-1:0]             host_be,
  output logic [DQ_W-1:0]               host_rdata,
  output logic                          host_done,
  output logic                          sd_cke,
  output logic                          sd_cs_n,
  output logic                          sd_ras_n,
  output logic                          sd_cas_n,
  output logic                          sd_we_n,
  output logic [BANK_W-1:0]             sd_ba,
  output logic [ROW_W-1:0]              sd_a,
  output logic [DQ_W-1:0]               sd_dq_out,
  output logic                          sd_dq_oe,
  input  logic [DQ_W-1:0]               sd_dq_in,
  output logic [DQ_W/8-1:0]             sd_dqm
);
  localparam int AW    = BANK_W + ROW_W + COL_W + 1;
  localparam int BEW   = DQ_W / 8;
  localparam int CFG_W = 5 * TF_W;
  localparam int AP    = 10;
  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD  = 4'b0101,
                         C_WR  = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
                         C_LMR = 4'b0000;
  localparam logic [ROW_W-1:0] LMR_VAL = ROW_W'(CAS_LAT << 4);
  localparam logic [CFG_W-1:0] CFG_RST = {TF_W'(DEF_TRC), TF_W'(DEF_TRAS),
                                          TF_W'(DEF_TRP), TF_W'(DEF_TRCD),
                                          TF_W'(DEF_TWR)};

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_REF, S_ACT, S_RCD, S_CL, S_PRE, S_FIN} st_t;

  st_t                st;
  logic [CFG_W-1:0]   cfg_q;
  logic [2:0]         mode_q;
  logic [RT_W-1:0]    rt_q, rt_cnt;
  logic               armed, ref_pend;
  logic [TF_W-1:0]    rc_c, rp_c, ras_c, wr_c;
  logic [WAIT_W-1:0]  dly;
  logic               a_wr;
  logic [BANK_W-1:0]  a_bank;
  logic [ROW_W-1:0]   a_row;
  logic [COL_W-1:0]   a_col;
  logic [DQ_W-1:0]    a_wdata;
  logic [BEW-1:0]     a_be;
  logic [3:0]         cmd_q;

  logic [TF_W-1:0] t_wr, t_rcd, t_rp, t_ras, t_rc;
  assign t_wr  = cfg_q[TF_W-1:0];
  assign t_rcd = cfg_q[2*TF_W-1:TF_W];
  assign t_rp  = cfg_q[3*TF_W-1:2*TF_W];
  assign t_ras = cfg_q[4*TF_W-1:3*TF_W];
  assign t_rc  = cfg_q[5*TF_W-1:4*TF_W];

  logic unused_bits;
  assign unused_bits = ^{host_addr[0], reg_wdata};

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

  function automatic logic [TF_W-1:0] ld(input logic [TF_W-1:0] t);
    return (t == '0) ? '0 : t - 1'b1;
  endfunction

  logic go, ref_fire, arm_ev, rt_hit;
  assign go       = (rc_c == '0) && (rp_c == '0);
  assign ref_fire = (st == S_REF) && go;
  assign arm_ev   = reg_wr && (reg_sel == 2'd1) && (reg_wdata[2:0] == 3'd0) && !armed;
  assign rt_hit   = armed && (rt_q != '0) && (rt_cnt == RT_W'(1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cfg_q  <= CFG_RST;
      mode_q <= 3'd1;
      rt_q   <= '0;
    end else if (reg_wr) begin
      case (reg_sel)
        2'd0:    cfg_q  <= reg_wdata[CFG_W-1:0];
        2'd1:    mode_q <= reg_wdata[2:0];
        2'd2:    rt_q   <= reg_wdata[RT_W-1:0];
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      armed    <= 1'b0;
      rt_cnt   <= '0;
      ref_pend <= 1'b0;
    end else begin
      if (arm_ev) armed <= 1'b1;
      if (reg_wr && reg_sel == 2'd2) rt_cnt <= reg_wdata[RT_W-1:0];
      else if (arm_ev)                rt_cnt <= rt_q;
      else if (armed && rt_q != '0)   rt_cnt <= (rt_cnt <= RT_W'(1)) ? rt_q : rt_cnt - 1'b1;
      ref_pend <= rt_hit | (ref_pend & ~ref_fire);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st         <= S_IDLE;
      cmd_q      <= C_NOP;
      sd_cke     <= 1'b0;
      sd_ba      <= '0;
      sd_a       <= '0;
      sd_dq_out  <= '0;
      sd_dq_oe   <= 1'b0;
      sd_dqm     <= '0;
      host_rdata <= '0;
      host_done  <= 1'b0;
      rc_c <= '0; rp_c <= '0; ras_c <= '0; wr_c <= '0;
      dly <= '0;
      a_wr <= 1'b0; a_bank <= '0; a_row <= '0; a_col <= '0;
      a_wdata <= '0; a_be <= '0;
    end else begin
      sd_cke    <= 1'b1;
      cmd_q     <= C_NOP;
      sd_dq_oe  <= 1'b0;
      sd_dqm    <= '0;
      host_done <= 1'b0;
      if (rc_c  != '0) rc_c  <= rc_c  - 1'b1;
      if (rp_c  != '0) rp_c  <= rp_c  - 1'b1;
      if (ras_c != '0) ras_c <= ras_c - 1'b1;
      if (wr_c  != '0) wr_c  <= wr_c  - 1'b1;
      case (st)
        S_IDLE:
          if (ref_pend) st <= S_REF;
          else if (host_req) begin
            a_wr    <= host_wr;
            a_col   <= host_addr[COL_W:1];
            a_row   <= host_addr[COL_W+ROW_W:COL_W+1];
            a_bank  <= host_addr[AW-1:COL_W+ROW_W+1];
            a_wdata <= host_wdata;
            a_be    <= host_be;
            st      <= (mode_q != 3'd0) ? S_CMD : S_ACT;
          end
        S_CMD:
          if (go && ras_c == '0) begin
            sd_ba <= '0;
            sd_a  <= '0;
            case (mode_q)
              3'd2: begin cmd_q <= C_PRE; sd_a[AP] <= 1'b1; rp_c <= ld(t_rp); end
              3'd3: begin cmd_q <= C_LMR; sd_a <= LMR_VAL; rc_c <= TF_W'(1); end
              3'd4: begin cmd_q <= C_REF; rc_c <= ld(t_rc); end
              3'd5: begin cmd_q <= C_LMR; sd_ba <= BANK_W'(1); rc_c <= TF_W'(1); end
              default: cmd_q <= C_NOP;
            endcase
            host_done <= 1'b1;
            st        <= S_FIN;
          end
        S_REF:
          if (go) begin
            cmd_q <= C_REF;
            rc_c  <= ld(t_rc);
            st    <= S_IDLE;
          end
        S_ACT:
          if (go) begin
            cmd_q <= C_ACT;
            sd_ba <= a_bank;
            sd_a  <= a_row;
            rc_c  <= ld(t_rc);
            ras_c <= ld(t_ras);
            dly   <= WAIT_W'(ld(t_rcd));
            st    <= S_RCD;
          end
        S_RCD:
          if (dly != '0) dly <= dly - 1'b1;
          else begin
            sd_ba <= a_bank;
            sd_a  <= ROW_W'(a_col);
            if (a_wr) begin
              cmd_q     <= C_WR;
              sd_dq_out <= a_wdata;
              sd_dq_oe  <= 1'b1;
              sd_dqm    <= ~a_be;
              wr_c      <= ld(t_wr);
              st        <= S_PRE;
            end else begin
              cmd_q <= C_RD;
              dly   <= WAIT_W'(CAS_LAT);
              st    <= S_CL;
            end
          end
        S_CL:
          if (dly != '0) dly <= dly - 1'b1;
          else begin
            host_rdata <= sd_dq_in;
            st         <= S_PRE;
          end
        S_PRE:
          if (ras_c == '0 && wr_c == '0) begin
            cmd_q     <= C_PRE;
            sd_ba     <= a_bank;
            sd_a      <= '0;
            rp_c      <= ld(t_rp);
            host_done <= 1'b1;
            st        <= S_FIN;
          end
        default: st <= S_IDLE;
      endcase
    end
endmodule

// File: rtl/sdr_ctrl_chk.sv
module sdr_ctrl_chk #(
  parameter int ROW_W  = 11,
  parameter int BANK_W = 1,
  parameter int TF_W   = 4,
  parameter int CAS_LAT = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [BANK_W-1:0] ba,
  input logic [ROW_W-1:0]  a,
  input logic              dq_oe,
  input logic [2:0]        mode,
  input logic [TF_W-1:0]   t_rcd,
  input logic [TF_W-1:0]   t_rp,
  input logic [TF_W-1:0]   t_ras,
  input logic [TF_W-1:0]   t_rc
);
  localparam logic [3:0] C_ACT = 4'b0011, C_RD = 4'b0101, C_WR = 4'b0100,
                         C_PRE = 4'b0010, C_REF = 4'b0001, C_LMR = 4'b0000;
  localparam logic [ROW_W-1:0] LMR_VAL = ROW_W'(CAS_LAT << 4);

  logic [3:0] cmd;
  logic [7:0] s_act, s_pre, s_rr;
  assign cmd = {cs_n, ras_n, cas_n, we_n};

  function automatic logic [7:0] inc(input logic [7:0] x);
    return (x == 8'hFF) ? x : x + 8'd1;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s_act <= 8'hFF; s_pre <= 8'hFF; s_rr <= 8'hFF;
    end else begin
      s_act <= (cmd == C_ACT) ? 8'd1 : inc(s_act);
      s_pre <= (cmd == C_PRE) ? 8'd1 : inc(s_pre);
      s_rr  <= (cmd == C_ACT || cmd == C_REF) ? 8'd1 : inc(s_rr);
    end

  a_r1_cke_high: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cke);
  a_r2_dq_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (cmd == C_WR));
  a_r4_pall_a10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_PRE && mode == 3'd2) |-> a[10]);
  a_r4_lmr_value: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_LMR && ba == '0) |-> (a == LMR_VAL));
  a_r5_rcd_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_RD || cmd == C_WR) |-> (s_act == ((t_rcd == '0) ? 8'd1 : 8'(t_rcd))));
  a_r7_ras_min: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_PRE && mode == 3'd0) |-> (!a[10] && s_act >= 8'(t_ras)));
  a_r8_rp_min: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_ACT || cmd == C_REF) |-> (s_pre >= 8'(t_rp)));
  a_r8_rc_min: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_ACT || cmd == C_REF) |-> (s_rr >= 8'(t_rc)));
endmodule

bind sdr_ctrl sdr_ctrl_chk #(.ROW_W(ROW_W), .BANK_W(BANK_W), .TF_W(TF_W), .CAS_LAT(CAS_LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cke(sd_cke), .cs_n(sd_cs_n), .ras_n(sd_ras_n),
  .cas_n(sd_cas_n), .we_n(sd_we_n), .ba(sd_ba), .a(sd_a), .dq_oe(sd_dq_oe),
  .mode(mode_q), .t_rcd(t_rcd), .t_rp(t_rp), .t_ras(t_ras), .t_rc(t_rc)
);

// File: tb/sim_sdr_ctrl.sv
module sim_sdr_ctrl;
  localparam int CL = 3;
  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                         C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
                         C_LMR = 4'b0000;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [1:0] reg_sel = 0;
  logic [31:0] reg_wdata = 0;
  logic host_req = 0, host_wr = 0;
  logic [20:0] host_addr = 0;
  logic [15:0] host_wdata = 0;
  logic [1:0] host_be = 0;
  logic [15:0] sd_dq_in = 0;
  wire [15:0] host_rdata, sd_dq_out, sd_a_w;
  wire host_done, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  wire [0:0] sd_ba;
  wire [10:0] sd_a;
  wire [1:0] sd_dqm;
  assign sd_a_w = 16'(sd_a);

  sdr_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .host_req(host_req), .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_be(host_be), .host_rdata(host_rdata), .host_done(host_done), .sd_cke(sd_cke),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_a(sd_a), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
    .sd_dq_in(sd_dq_in), .sd_dqm(sd_dqm)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  int tot = 0, bad = 0, m_tot = 0, m_bad = 0, wd_bad = 0;
  int tb_wr = 4, tb_rcd = 5, tb_rp = 5, tb_ras = 8, tb_rc = 11;
  int n_act = 0, n_rd = 0, n_wr = 0, n_pre = 0, n_ref = 0, n_lmr = 0;
  int last_act = 0, last_rr = -1000, last_pre = -1000, last_wr = 0, last_ref = 0, prev_ref = 0;
  bit was_wr = 0;
  logic pre_a10 = 0, lmr_ba = 0;
  logic [10:0] lmr_a = 0;
  logic exp_ba = 0;
  logic [10:0] exp_row = 0;
  logic [7:0] exp_col = 0;
  logic [15:0] exp_wd = 0, exp_rd = 0;
  logic [1:0] exp_be = 0;

  function automatic logic [15:0] pat(input int c);
    return 16'hC35A ^ 16'(c * 37);
  endfunction

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    tot++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", r, act, exp, cyc); end
  endtask

  task automatic mchk(input bit ok, input string r, input int act, input int exp);
    m_tot++;
    if (!ok) begin m_bad++; $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", r, act, exp, cyc); end
  endtask

  initial forever begin @(posedge clk); cyc++; end
  initial forever begin @(negedge clk); sd_dq_in = pat(cyc); end

  // pin monitor: R2 decode, R5/R6/R7/R8/R11 spacing and fields
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      case ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n})
        C_ACT: begin
          n_act++;
          mchk(cyc - last_rr >= tb_rc, "R8 act-after-act/ref", cyc - last_rr, tb_rc);
          mchk(cyc - last_pre >= tb_rp, "R8 act-after-pre", cyc - last_pre, tb_rp);
          mchk(sd_ba == exp_ba && sd_a == exp_row, "R11 row/bank", {sd_ba, sd_a}, {exp_ba, exp_row});
          last_act = cyc; last_rr = cyc;
        end
        C_RD, C_WR: begin
          mchk(cyc - last_act == tb_rcd, "R5 rcd", cyc - last_act, tb_rcd);
          mchk(sd_a == {3'b000, exp_col} && sd_ba == exp_ba, "R11 column", sd_a, {3'b000, exp_col});
          if (!sd_we_n) begin
            n_wr++;
            mchk(sd_dq_oe && sd_dq_out == exp_wd, "R5 write data", sd_dq_out, exp_wd);
            mchk(sd_dqm == ~exp_be, "R5 dqm", sd_dqm, ~exp_be);
            last_wr = cyc; was_wr = 1;
          end else begin
            n_rd++;
            exp_rd = pat(cyc + CL); was_wr = 0;
          end
        end
        C_PRE: begin
          n_pre++;
          pre_a10 = sd_a[10];
          if (!sd_a[10]) begin
            mchk(cyc - last_act >= tb_ras, "R7 ras", cyc - last_act, tb_ras);
            if (was_wr) mchk(cyc - last_wr >= tb_wr, "R7 write recovery", cyc - last_wr, tb_wr);
          end
          last_pre = cyc;
        end
        C_REF: begin
          n_ref++;
          mchk(cyc - last_rr >= tb_rc, "R8 ref-after-act/ref", cyc - last_rr, tb_rc);
          mchk(cyc - last_pre >= tb_rp, "R10 ref-after-pre", cyc - last_pre, tb_rp);
          prev_ref = last_ref; last_ref = cyc; last_rr = cyc;
        end
        C_LMR: begin n_lmr++; lmr_ba = sd_ba[0]; lmr_a = sd_a; end
        C_NOP: ;
        default: mchk(0, "R2 illegal command", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
      endcase
    end
  end

  task automatic reg_write(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic access(input bit wr, input logic [20:0] ad, input logic [15:0] wd, input logic [1:0] be);
    bit seen;
    exp_ba = ad[20]; exp_row = ad[19:9]; exp_col = ad[8:1]; exp_wd = wd; exp_be = be;
    @(negedge clk);
    host_wr = wr; host_addr = ad; host_wdata = wd; host_be = be; host_req = 1;
    seen = 0;
    for (int k = 0; k < 300 && !seen; k++) begin
      @(negedge clk);
      seen = host_done;
    end
    host_req = 0;
    chk(seen, "R7 done pulse", seen, 1);
  endtask

  task automatic normal(input bit wr, input logic [20:0] ad, input logic [15:0] wd, input logic [1:0] be);
    int a0;
    a0 = n_act;
    access(wr, ad, wd, be);
    chk(n_act == a0 + 1, "R5 one activate", n_act - a0, 1);
    chk(pre_a10 == 0, "R7 single-bank precharge", pre_a10, 0);
    if (!wr) chk(host_rdata == exp_rd, "R6 read data", host_rdata, exp_rd);
  endtask

  task automatic mode_cmd(input int m, input int d_pre, input int d_ref, input int d_lmr);
    int a0, p0, r0, l0, rw0;
    reg_write(2'd1, m);
    a0 = n_act; p0 = n_pre; r0 = n_ref; l0 = n_lmr; rw0 = n_rd + n_wr;
    access(1, 21'h1ABCD, 16'hFFFF, 2'b11);
    @(negedge clk);
    chk(n_act == a0 && n_rd + n_wr == rw0, "R3 no data access", n_act - a0, 0);
    chk(n_pre - p0 == d_pre && n_ref - r0 == d_ref && n_lmr - l0 == d_lmr, "R3 single command",
        (n_pre - p0) * 256 + (n_ref - r0) * 16 + (n_lmr - l0), d_pre * 256 + d_ref * 16 + d_lmr);
  endtask

  task automatic rand_run(input int n);
    for (int i = 0; i < n; i++)
      normal($urandom_range(0, 1), 21'($urandom), 16'($urandom), 2'($urandom));
  endtask

  initial begin
    int r0, c0, exp_n;
    void'($urandom(32'd20240607));
    repeat (5) @(negedge clk);
    chk(sd_cke == 0, "R1 cke in reset", sd_cke, 0);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R1 nop in reset",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
    chk(host_done == 0, "R1 done in reset", host_done, 0);
    rst_n = 1;
    @(negedge clk);
    chk(sd_cke == 1, "R1 cke after reset", sd_cke, 1);

    // R9: interval loaded but not armed: no refresh
    reg_write(2'd2, 200);
    repeat (600) @(negedge clk);
    chk(n_ref == 0, "R9 idle before normal mode", n_ref, 0);

    // R3/R4: host-driven power-up
    mode_cmd(1, 0, 0, 0);
    mode_cmd(2, 1, 0, 0);
    chk(pre_a10 == 1, "R4 precharge-all A10", pre_a10, 1);
    for (int i = 0; i < 8; i++) mode_cmd(4, 0, 1, 0);
    chk(n_ref == 8, "R3 eight refreshes", n_ref, 8);
    mode_cmd(3, 0, 0, 1);
    chk(lmr_ba == 0 && lmr_a == 11'h030, "R4 load mode value", {lmr_ba, lmr_a}, 12'h030);
    mode_cmd(5, 0, 0, 1);
    chk(lmr_ba == 1 && lmr_a == 11'h000, "R4 extended load mode", {lmr_ba, lmr_a}, 12'h800);

    // R9: arm and measure the idle period
    r0 = n_ref;
    reg_write(2'd1, 0);
    repeat (1100) @(negedge clk);
    chk(n_ref - r0 == 5, "R9 refresh count in window", n_ref - r0, 5);
    chk(last_ref - prev_ref == 200, "R9 refresh period", last_ref - prev_ref, 200);

    // R9: zero disables
    reg_write(2'd2, 0);
    repeat (5) @(negedge clk);
    r0 = n_ref;
    repeat (800) @(negedge clk);
    chk(n_ref == r0, "R9 zero interval stops refresh", n_ref - r0, 0);

    // directed corners: R5 R6 R11
    normal(1, 21'h000000, 16'h1234, 2'b11);
    normal(1, 21'h1FFFFF, 16'hBEEF, 2'b00);
    normal(1, 21'h100201, 16'h00A5, 2'b01);
    normal(1, 21'h0FFE00, 16'h5A00, 2'b10);
    normal(0, 21'h1FFFFF, 16'h0, 2'b11);
    normal(0, 21'h000000, 16'h0, 2'b00);

    // R10: refresh due during accesses
    reg_write(2'd2, 45);
    c0 = cyc; r0 = n_ref;
    rand_run(150);
    exp_n = (cyc - c0) / 45;
    chk(n_ref - r0 >= exp_n - 1 && n_ref - r0 <= exp_n + 1, "R10 no refresh lost", n_ref - r0, exp_n);

    // R12: tighter timing set
    repeat (20) @(negedge clk);
    reg_write(2'd0, {12'd0, 4'd9, 4'd6, 4'd3, 4'd2, 4'd2});
    tb_rc = 9; tb_ras = 6; tb_rp = 3; tb_rcd = 2; tb_wr = 2;
    c0 = cyc; r0 = n_ref;
    rand_run(120);
    exp_n = (cyc - c0) / 45;
    chk(n_ref - r0 >= exp_n - 1 && n_ref - r0 <= exp_n + 1, "R12 refresh with new timing", n_ref - r0, exp_n);
    normal(1, 21'h0AAAAA, 16'hC0DE, 2'b11);
    normal(0, 21'h155555, 16'h0, 2'b11);

    repeat (10) @(negedge clk);
    $display("test done: total=%0d bad=%0d", tot + m_tot, bad + m_bad + wd_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    wd_bad = 1;
    $display("FAIL watchdog expired actual=%0d expected=finished", cyc);
    $display("test done: total=%0d bad=%0d", tot + m_tot + 1, bad + m_bad + wd_bad);
    $finish;
  end
endmodule